// File: doc/BRIEF.md
# Event monitor slice

This block counts hardware events for one slice of a shared cache and raises an interrupt when a count needs attention. It has eight 32-bit counters. Each counter picks one of 256 event strobe lines through an 8-bit selector. Selector code 0x01 counts every clock, and code 0x00 counts nothing. The strobe lines with codes 0x20 to 0x25 are meant for read hits and misses, data-side read hits and misses, and write hits and misses. Software controls the block through a plain 32-bit register bus. Reads return data in the same cycle the address is presented. A write takes effect at the clock edge on which `bus_en` and `bus_we` are both high.

Software starts and stops the whole unit with one bit and can zero every count with another. Each counter has its own run bit and interrupt-enable bit. Each of these bit sets has a set address and a clear address, so one counter can be changed without a read-modify-write. Counter values can be written to preload a start point. A chain mask turns counter n into the upper half of a 64-bit count, with counter n-1 as the lower half. A per-counter mode raises the overflow flag when bit 31 turns on, in place of the flag at wraparound. The per-counter control words and the address-filter words are decoded but always read zero.

Top module: `evmon_slice`

## Requirements
- R1: After reset, every register reads zero and `irq` is low: control 0x500, all enable masks, chain mask 0x718, MSB-mode mask 0x96C, overflow 0x740, counters 0x420+8n and selectors 0x220+8n.
- R2: A counter whose selector holds code c (bits 7:0 of a write to 0x220+8n; upper bits are dropped) adds one on each clock where the unit runs, the counter is enabled and strobe line c is high. Code 0x01 adds one every clock. Code 0x00 never adds.
- R3: Bit 0 of control register 0x500 is the unit run bit. While it is 0, no counter value changes except by a write. Bit 0 reads back.
- R4: Writing control 0x500 with bit 1 set zeroes all counter values and all overflow flags in that cycle. Bit 1 always reads 0.
- R5: Counter run bits: writing 0x508 sets every bit written as 1, and writing 0x50C clears every bit written as 1. Bits written 0 are left unchanged. Both addresses read the current mask, bit n for counter n.
- R6: Interrupt-enable bits use the same rules at 0x510 (set) and 0x514 (clear).
- R7: Writing 0x420+8n loads counter n. The write wins over an increment in the same cycle, and counting continues from the loaded value.
- R8: A counter that is not in MSB mode sets overflow bit n in 0x740 on the increment that wraps it from 0xFFFFFFFF to 0. The increment before the wrap does not set it.
- R9: With bit n of 0x96C set, counter n sets its overflow flag on the step from 0x7FFFFFFF to 0x80000000 and not on wraparound.
- R10: Writing 0x740 clears each flag written as 1. Flags written as 0 are left unchanged.
- R11: `irq` is high exactly when some overflow flag and the matching interrupt-enable bit are both set.
- R12: Chain mask bit n (n >= 1) at 0x718 makes counter n add one only in the cycle counter n-1 wraps, and counter n then ignores its own selector. The wrap of counter n-1 sets no flag, and counter n flags by its own mode. Bit 0 reads 0.
- R13: The per-counter control words at 0x120+8n and the filter words 0x300 to 0x314 accept writes and always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| ev_strobe | input | 256 | One event strobe per selector code |
| irq | output | 1 | Level interrupt: pending overflow with its enable set |

## Verification
Wrong internal state shows up at the ports within one clock. A counter that ignored its run or chain gating reads a different value on the next read. A flag that was missed or raised by mistake shows in the overflow register, and it shows on `irq` once the matching enable is set. The boundary cases are the ones that move flags: the wrap from all ones, the step into bit 31 in MSB mode, and a wrap of the lower half of a chained pair. Each is reached by preloading a value one or two events from the edge and then reading the flags at the step before the edge and at the edge itself.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

    localparam int NUM_CNT_DEF = 8;
    localparam int CNT_W_DEF   = 32;
    localparam int EVT_W_DEF   = 8;
    localparam int ADDR_W_DEF  = 12;
    localparam int DATA_W_DEF  = 32;

    // bank spacing of per-counter registers
    localparam int REG_STRIDE = 8;

    // register map (byte offsets)
    localparam int OFS_CTRL      = 'h500;
    localparam int OFS_RUN_SET   = 'h508;
    localparam int OFS_RUN_CLR   = 'h50C;
    localparam int OFS_IEN_SET   = 'h510;
    localparam int OFS_IEN_CLR   = 'h514;
    localparam int OFS_CHAIN     = 'h718;
    localparam int OFS_OVF       = 'h740;
    localparam int OFS_MSB_MODE  = 'h96C;
    localparam int OFS_CNT_BASE  = 'h420;
    localparam int OFS_SEL_BASE  = 'h220;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_CLR_BIT = 1;

    localparam int EVT_CODE_NONE  = 0;
    localparam int EVT_CODE_CLOCK = 1;

    // gating presented to one counter
    typedef struct packed {
        logic run;       // unit running and counter enabled
        logic chain;     // counter is the upper half of a pair
        logic chain_in;  // lower partner wraps this cycle
        logic msb_mode;  // flag on entry into top bit
    } cnt_ctl_t;

    // events reported by one counter
    typedef struct packed {
        logic wrap;      // increments from all-ones this cycle
        logic ovf_evt;   // flag condition for its own mode
    } cnt_evt_t;

    function automatic int bank_ofs(input int base, input int idx);
        return base + idx * REG_STRIDE;
    endfunction

endpackage

// File: rtl/evmon_counter.sv
module evmon_counter
    import evmon_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int EVT_W = EVT_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    val_we,
    input  logic [CNT_W-1:0]        val_wdata,
    input  logic                    sel_we,
    input  logic [EVT_W-1:0]        sel_wdata,
    input  logic [(1<<EVT_W)-1:0]   ev_strobe,
    input  cnt_ctl_t                ctl,
    output logic [CNT_W-1:0]        value,
    output logic [EVT_W-1:0]        evsel,
    output cnt_evt_t                stat
);

    localparam logic [CNT_W-1:0] MSB_EDGE = {1'b0, {(CNT_W-1){1'b1}}};

    logic [CNT_W-1:0] val_q;
    logic [EVT_W-1:0] sel_q;
    logic             hit;
    logic             inc;

    always_comb begin
        hit = 1'b0;
        if (sel_q == EVT_W'(EVT_CODE_CLOCK))
            hit = 1'b1;
        else if (sel_q != EVT_W'(EVT_CODE_NONE))
            hit = ev_strobe[sel_q];
        inc = ctl.run && (ctl.chain ? ctl.chain_in : hit);
    end

    always_comb begin
        stat.wrap    = inc && (&val_q);
        stat.ovf_evt = inc && (ctl.msb_mode ? (val_q == MSB_EDGE) : (&val_q));
    end

    always_ff @(posedge clk) begin
        if (rst)
            val_q <= '0;
        else if (val_we)
            val_q <= val_wdata;
        else if (clear)
            val_q <= '0;
        else if (inc)
            val_q <= val_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (sel_we)
            sel_q <= sel_wdata;
    end

    assign value = val_q;
    assign evsel = sel_q;

    // R3: a stopped counter keeps its value unless software writes it
    a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!ctl.run && !val_we && !clear) |=> $stable(val_q));

    // R12: an upper half moves only with its partner's wrap
    a_r12_upper_waits_for_carry: assert property (@(posedge clk) disable iff (rst)
        (ctl.chain && !ctl.chain_in && !val_we && !clear) |=> $stable(val_q));

    // R7: a preload lands in the next cycle
    a_r7_preload_lands: assert property (@(posedge clk) disable iff (rst)
        val_we |=> (val_q == $past(val_wdata)));

endmodule

// File: rtl/evmon_setclr.sv
module evmon_setclr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (set_we)
            q <= q | wdata;
        else if (clr_we)
            q <= q & ~wdata;
    end

    // R5 and R6: ones written to the set address appear in the mask
    a_r5_r6_set_lands: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((q & $past(wdata)) == $past(wdata)));

    // R5 and R6: ones written to the clear address leave the mask
    a_r5_r6_clear_lands: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((q & $past(wdata)) == '0));

endmodule

// File: rtl/evmon_status.sv
module evmon_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_all,
    input  logic [N-1:0] set_mask,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] inten,
    output logic [N-1:0] flags,
    output logic         irq
);

    logic [N-1:0] drop;

    assign drop = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else if (clear_all)
            flags <= '0;
        else
            flags <= (flags & ~drop) | set_mask;
    end

    assign irq = |(flags & inten);

    // R10: a flag rises only after a counter reported its condition
    a_r10_flag_has_source: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flags & ~$past(flags) & ~$past(set_mask)) == '0));

endmodule

// File: rtl/evmon_slice.sv
module evmon_slice
    import evmon_pkg::*;
#(
    parameter int NUM_CNT = NUM_CNT_DEF,
    parameter int CNT_W   = CNT_W_DEF,
    parameter int EVT_W   = EVT_W_DEF,
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int DATA_W  = DATA_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_en,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [(1<<EVT_W)-1:0]   ev_strobe,
    output logic                    irq
);

    localparam logic [NUM_CNT-1:0] NO_CHAIN_AT_ZERO = NUM_CNT'(1);

    function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    logic               wr;
    logic               run_q;
    logic               unit_clear;
    logic [NUM_CNT-1:0] run_mask;
    logic [NUM_CNT-1:0] ien_mask;
    logic [NUM_CNT-1:0] chain_q;
    logic [NUM_CNT-1:0] msb_q;
    logic [NUM_CNT-1:0] ovf_q;
    logic [NUM_CNT-1:0] ovf_set;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];
    logic [EVT_W-1:0]   sel_val [NUM_CNT];

    assign wr         = bus_en && bus_we;
    assign unit_clear = wr && at(bus_addr, OFS_CTRL) && bus_wdata[CTRL_CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= 1'b0;
        else if (wr && at(bus_addr, OFS_CTRL))
            run_q <= bus_wdata[CTRL_RUN_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            msb_q   <= '0;
        end else begin
            if (wr && at(bus_addr, OFS_CHAIN))
                chain_q <= bus_wdata[NUM_CNT-1:0] & ~NO_CHAIN_AT_ZERO;
            if (wr && at(bus_addr, OFS_MSB_MODE))
                msb_q <= bus_wdata[NUM_CNT-1:0];
        end
    end

    evmon_setclr #(.W(NUM_CNT)) u_run_mask (
        .clk    (clk),
        .rst    (rst),
        .set_we (wr && at(bus_addr, OFS_RUN_SET)),
        .clr_we (wr && at(bus_addr, OFS_RUN_CLR)),
        .wdata  (bus_wdata[NUM_CNT-1:0]),
        .q      (run_mask)
    );

    evmon_setclr #(.W(NUM_CNT)) u_ien_mask (
        .clk    (clk),
        .rst    (rst),
        .set_we (wr && at(bus_addr, OFS_IEN_SET)),
        .clr_we (wr && at(bus_addr, OFS_IEN_CLR)),
        .wdata  (bus_wdata[NUM_CNT-1:0]),
        .q      (ien_mask)
    );

    evmon_status #(.N(NUM_CNT)) u_status (
        .clk       (clk),
        .rst       (rst),
        .clear_all (unit_clear),
        .set_mask  (ovf_set),
        .clr_we    (wr && at(bus_addr, OFS_OVF)),
        .clr_mask  (bus_wdata[NUM_CNT-1:0]),
        .inten     (ien_mask),
        .flags     (ovf_q),
        .irq       (irq)
    );

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        cnt_ctl_t ctl;
        cnt_evt_t st;
        logic     carry_in;
        logic     wrap_o;
        logic     val_we;
        logic     sel_we;

        if (gi == 0) begin : g_head
            assign carry_in = 1'b0;
        end else begin : g_link
            assign carry_in = g_cnt[gi-1].wrap_o;
        end

        // a lower half that carries into a chained partner never flags
        if (gi == NUM_CNT - 1) begin : g_last
            assign ovf_set[gi] = st.ovf_evt;
        end else begin : g_mid
            assign ovf_set[gi] = st.ovf_evt & ~chain_q[gi+1];
        end

        assign wrap_o = st.wrap;
        assign val_we = wr && at(bus_addr, bank_ofs(OFS_CNT_BASE, gi));
        assign sel_we = wr && at(bus_addr, bank_ofs(OFS_SEL_BASE, gi));

        always_comb begin
            ctl.run      = run_q && run_mask[gi];
            ctl.chain    = chain_q[gi];
            ctl.chain_in = carry_in;
            ctl.msb_mode = msb_q[gi];
        end

        evmon_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_counter (
            .clk       (clk),
            .rst       (rst),
            .clear     (unit_clear),
            .val_we    (val_we),
            .val_wdata (bus_wdata[CNT_W-1:0]),
            .sel_we    (sel_we),
            .sel_wdata (bus_wdata[EVT_W-1:0]),
            .ev_strobe (ev_strobe),
            .ctl       (ctl),
            .value     (cnt_val[gi]),
            .evsel     (sel_val[gi]),
            .stat      (st)
        );
    end

    // read path: unknown, control-word and filter addresses return zero
    always_comb begin
        bus_rdata = '0;
        if (at(bus_addr, OFS_CTRL))
            bus_rdata = DATA_W'(run_q);
        if (at(bus_addr, OFS_RUN_SET) || at(bus_addr, OFS_RUN_CLR))
            bus_rdata = DATA_W'(run_mask);
        if (at(bus_addr, OFS_IEN_SET) || at(bus_addr, OFS_IEN_CLR))
            bus_rdata = DATA_W'(ien_mask);
        if (at(bus_addr, OFS_CHAIN))
            bus_rdata = DATA_W'(chain_q);
        if (at(bus_addr, OFS_MSB_MODE))
            bus_rdata = DATA_W'(msb_q);
        if (at(bus_addr, OFS_OVF))
            bus_rdata = DATA_W'(ovf_q);
        for (int i = 0; i < NUM_CNT; i++) begin
            if (at(bus_addr, bank_ofs(OFS_CNT_BASE, i)))
                bus_rdata = DATA_W'(cnt_val[i]);
            if (at(bus_addr, bank_ofs(OFS_SEL_BASE, i)))
                bus_rdata = DATA_W'(sel_val[i]);
        end
    end

    // R4: a unit clear leaves no flag and a zero first counter
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (rst)
        unit_clear |=> ((ovf_q == '0) && (cnt_val[0] == '0)));

    // R11: the interrupt never stands without a pending flag
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ovf_q != '0));

endmodule

// File: tb/evmon_slice_bench.sv
`timescale 1ns/1ps
module evmon_slice_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_en = 1'b0;
    logic         bus_we = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [255:0] ev = '0;
    logic         irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evmon_slice u_evmon_slice (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ev_strobe (ev),
        .irq       (irq)
    );

    localparam logic [11:0] A_CTRL  = 12'h500;
    localparam logic [11:0] A_RSET  = 12'h508;
    localparam logic [11:0] A_RCLR  = 12'h50C;
    localparam logic [11:0] A_ISET  = 12'h510;
    localparam logic [11:0] A_ICLR  = 12'h514;
    localparam logic [11:0] A_CHAIN = 12'h718;
    localparam logic [11:0] A_OVF   = 12'h740;
    localparam logic [11:0] A_MSB   = 12'h96C;

    function automatic logic [11:0] a_cnt(input int i);
        return 12'(12'h420 + 8 * i);
    endfunction
    function automatic logic [11:0] a_sel(input int i);
        return 12'(12'h220 + 8 * i);
    endfunction

    typedef struct packed {
        logic [15:0] sel;
        logic [7:0]  line;
        logic [7:0]  cyc;
        logic [7:0]  expc;
    } vec_t;

    // R2 vectors: selector written, strobe line held, cycles held, expected count
    localparam vec_t VEC [6] = '{
        '{16'h0020, 8'h20, 8'd5, 8'd5},
        '{16'h0021, 8'h20, 8'd5, 8'd0},
        '{16'h0001, 8'h00, 8'd7, 8'd8},
        '{16'h0000, 8'h00, 8'd4, 8'd0},
        '{16'h0125, 8'h25, 8'd3, 8'd3},
        '{16'h0023, 8'h23, 8'd1, 8'd1}
    };

    // every task starts and ends just after a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic pulse(input int line, input int n);
        ev[line] = 1'b1;
        repeat (n) @(negedge clk);
        ev[line] = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] expv);
        n_cmp++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, expv);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [11:0] a, input logic [31:0] expv);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, expv);
    endtask

    initial begin
        logic [31:0] d, d2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk_rd("R1 ctrl", A_CTRL, 32'h0);
        chk_rd("R1 counter3", a_cnt(3), 32'h0);
        chk_rd("R1 selector6", a_sel(6), 32'h0);
        chk_rd("R1 run mask", A_RSET, 32'h0);
        chk_rd("R1 irq mask", A_ISET, 32'h0);
        chk_rd("R1 overflow", A_OVF, 32'h0);
        chk_rd("R1 chain", A_CHAIN, 32'h0);
        chk_rd("R1 msb mode", A_MSB, 32'h0);
        chk_rd("R1 filter", 12'h310, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R5: set and clear of counter run bits
        wr(A_RSET, 32'h05);
        chk_rd("R5 set", A_RSET, 32'h05);
        wr(A_RSET, 32'h00);
        chk_rd("R5 zero write", A_RCLR, 32'h05);
        wr(A_RCLR, 32'h04);
        chk_rd("R5 clear", A_RCLR, 32'h01);
        wr(A_RCLR, 32'hFF);

        // R6: interrupt-enable set and clear
        wr(A_ISET, 32'h82);
        wr(A_ICLR, 32'h00);
        chk_rd("R6 set", A_ICLR, 32'h82);
        wr(A_ICLR, 32'h80);
        chk_rd("R6 clear", A_ISET, 32'h02);
        wr(A_ICLR, 32'hFF);

        wr(A_CTRL, 32'h1);
        chk_rd("R3 run bit readback", A_CTRL, 32'h1);

        // R2: vector table on counter 0
        for (int k = 0; k < 6; k++) begin
            wr(a_sel(0), 32'(VEC[k].sel));
            wr(a_cnt(0), 32'h0);
            wr(A_RSET, 32'h1);
            ev[VEC[k].line] = 1'b1;
            repeat (int'(VEC[k].cyc)) @(negedge clk);
            ev[VEC[k].line] = 1'b0;
            wr(A_RCLR, 32'h1);
            rd(a_cnt(0), d);
            chk($sformatf("R2 vector %0d", k), d, 32'(VEC[k].expc));
        end
        chk_rd("R2 selector width", a_sel(0), 32'h23);
        wr(a_sel(0), 32'h125);
        chk_rd("R2 selector masked", a_sel(0), 32'h25);

        // R3: unit stop freezes counting
        wr(a_sel(0), 32'h01);
        wr(a_cnt(0), 32'h0);
        wr(A_RSET, 32'h1);
        repeat (5) @(negedge clk);
        wr(A_CTRL, 32'h0);
        rd(a_cnt(0), d);
        repeat (4) @(negedge clk);
        rd(a_cnt(0), d2);
        chk("R3 frozen", d2, d);
        chk("R3 had counted", 32'(d != 0), 32'h1);

        // R7: preload wins and counting resumes
        wr(A_CTRL, 32'h1);
        wr(a_cnt(0), 32'h100);
        chk_rd("R7 preload", a_cnt(0), 32'h100);
        chk_rd("R7 continues", a_cnt(0), 32'h101);
        wr(A_RCLR, 32'hFF);
        wr(a_cnt(3), 32'h1234);
        chk_rd("R7 idle preload", a_cnt(3), 32'h1234);

        // R8: wraparound flag, R11 interrupt
        wr(a_sel(2), 32'h22);
        wr(a_cnt(2), 32'hFFFF_FFFE);
        wr(A_ISET, 32'h04);
        wr(A_RSET, 32'h04);
        pulse(8'h22, 1);
        chk_rd("R8 no early flag", A_OVF, 32'h0);
        pulse(8'h22, 1);
        chk_rd("R8 wrapped value", a_cnt(2), 32'h0);
        chk_rd("R8 flag", A_OVF, 32'h04);
        chk("R11 irq raised", 32'(irq), 32'h1);

        // R10: write-one-to-clear
        wr(A_OVF, 32'h0);
        chk_rd("R10 zero write", A_OVF, 32'h04);
        wr(A_OVF, 32'hFB);
        chk_rd("R10 other bits", A_OVF, 32'h04);
        wr(A_OVF, 32'h04);
        chk_rd("R10 cleared", A_OVF, 32'h0);
        chk("R11 irq dropped", 32'(irq), 32'h0);

        // R11: flag without enable
        wr(A_ICLR, 32'h04);
        wr(a_cnt(2), 32'hFFFF_FFFF);
        pulse(8'h22, 1);
        chk_rd("R11 flag pending", A_OVF, 32'h04);
        chk("R11 masked irq", 32'(irq), 32'h0);
        wr(A_ISET, 32'h04);
        chk("R11 enabled irq", 32'(irq), 32'h1);
        wr(A_OVF, 32'hFF);
        wr(A_ICLR, 32'hFF);
        wr(A_RCLR, 32'hFF);

        // R9: flag on entry into bit 31
        wr(A_MSB, 32'h10);
        chk_rd("R9 mode readback", A_MSB, 32'h10);
        wr(a_sel(4), 32'h23);
        wr(a_cnt(4), 32'h7FFF_FFFE);
        wr(A_RSET, 32'h10);
        pulse(8'h23, 1);
        chk_rd("R9 before edge", A_OVF, 32'h0);
        pulse(8'h23, 1);
        chk_rd("R9 top bit value", a_cnt(4), 32'h8000_0000);
        chk_rd("R9 top bit flag", A_OVF, 32'h10);
        wr(A_OVF, 32'h10);
        wr(a_cnt(4), 32'hFFFF_FFFF);
        pulse(8'h23, 1);
        chk_rd("R9 wrap value", a_cnt(4), 32'h0);
        chk_rd("R9 no wrap flag", A_OVF, 32'h0);
        wr(A_MSB, 32'h0);
        wr(A_RCLR, 32'hFF);

        // R12: chained pair 1:0
        wr(A_CHAIN, 32'h03);
        chk_rd("R12 bit0 reads zero", A_CHAIN, 32'h02);
        wr(a_sel(0), 32'h24);
        wr(a_sel(1), 32'h24);
        wr(a_cnt(0), 32'hFFFF_FFFF);
        wr(a_cnt(1), 32'h5);
        wr(A_RSET, 32'h03);
        pulse(8'h24, 3);
        chk_rd("R12 lower", a_cnt(0), 32'h2);
        chk_rd("R12 upper carry only", a_cnt(1), 32'h6);
        chk_rd("R12 lower wrap silent", A_OVF, 32'h0);
        wr(a_cnt(0), 32'hFFFF_FFFF);
        wr(a_cnt(1), 32'hFFFF_FFFF);
        pulse(8'h24, 1);
        chk_rd("R12 lower zero", a_cnt(0), 32'h0);
        chk_rd("R12 upper zero", a_cnt(1), 32'h0);
        chk_rd("R12 upper flags", A_OVF, 32'h02);
        wr(A_RCLR, 32'hFF);

        // R4: unit clear
        wr(a_cnt(5), 32'h55);
        wr(A_CTRL, 32'h3);
        chk_rd("R4 counter cleared", a_cnt(5), 32'h0);
        chk_rd("R4 flags cleared", A_OVF, 32'h0);
        chk_rd("R4 clear bit reads zero", A_CTRL, 32'h1);
        wr(A_CHAIN, 32'h0);

        // R13: placeholder words
        wr(12'h300, 32'hFFFF_FFFF);
        chk_rd("R13 filter low", 12'h300, 32'h0);
        wr(12'h314, 32'hA5A5_A5A5);
        chk_rd("R13 filter high", 12'h314, 32'h0);
        wr(12'h158, 32'h1);
        chk_rd("R13 control word", 12'h158, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements) got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule